// File: doc/BRIEF.md
# Interrupt Controller Command Port Decoder

This block is the register front end of an 8-input priority interrupt controller. A host writes through two addresses, selected by one address bit. Address 0 takes three kinds of command, told apart by data bits 4 and 3. Address 1 takes mask writes and the later words of a multi-word initialization sequence. The decoder keeps that sequence state. It holds the configuration that the priority core uses: mask, vector base, automatic end-of-interrupt, rotation offset, read select, special mask, and rotate-on-automatic-EOI. It issues one-cycle pulses that clear in-service bits and flush the core's state.

The priority core supplies three inputs. It gives the request and in-service registers, which are returned on reads. It also gives the absolute level of the highest-priority bit now in service, with a valid flag, so that a non-specific end-of-interrupt knows which bit to clear. A write is a single-cycle strobe and is always accepted. The write port has no back-pressure and no ready signal, so the host may issue a write on every cycle. Reads are combinational.

Top module: `picport_top`

## Requirements
- R1: A write to address 0 with data bit 4 set is an initialization word. On the next cycle the mask, vector base, auto-EOI flag, rotation offset, read select, special mask and rotate-on-auto-EOI flag are all zero, and `init_busy` is 1. `core_clear` is high for that one cycle. `fourth_expected` takes data bit 0, and `mode_unsup` takes (data bit 1 OR data bit 3).
- R2: After an initialization word, writes to address 1 step through the sequence in order. The first write loads `vec_base` from data bits 7:3. The second write changes no configuration; it ends the sequence if `fourth_expected` is 0 and otherwise waits for one more word. That further word loads `auto_eoi` from data bit 1 and ends the sequence. `init_busy` is 0 once the sequence has ended.
- R3: A write to address 1 while `init_busy` is 0 loads `mask` with the full data byte.
- R4: A write to address 0 with bit 4 = 0 and bit 3 = 1 is a control word. If bit 1 is set, `rd_sel_isr` takes bit 0. If bit 6 is set, `spec_mask` takes bit 5. Each of these fields is otherwise unchanged.
- R5: Code 0x00 clears `rot_auto_eoi` and code 0x80 sets it.
- R6: Code 0x20 drives `isr_clr` to the one-hot mask of `isr_top_lvl` for exactly the cycle after the write, but only if `isr_top_valid` was 1 at the write. Otherwise `isr_clr` stays zero.
- R7: Code 0xA0 acts as 0x20 and also advances `rot_off` by one, modulo 8. This happens even when nothing is in service.
- R8: Codes 0x60 to 0x67 pulse `isr_clr` for one cycle at the level given by data bits 2:0.
- R9: Codes 0xC0 to 0xC7 set `rot_off` to (bits 2:0 + 1) mod 8.
- R10: Codes 0xE0 to 0xE7 pulse `isr_clr` at level L, where L is bits 2:0, and set `rot_off` to (L + 1) mod 8.
- R11: Any other code with bits 4 and 3 both clear has no effect. Examples are 0x01, 0x21, 0x40 to 0x47 and 0xA3.
- R12: `rd_data` is combinational. With `rd_addr` = 1 it shows `mask`. With `rd_addr` = 0 it shows `isr_in` when `rd_sel_isr` = 1, and `irr_in` when `rd_sel_isr` = 0.
- R13: After reset every output register is zero. No output register changes on a cycle without a write. `isr_clr` and `core_clear` are zero on every cycle except the one that follows their causing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 1 | Write address bit |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address bit |
| rd_data | output | 8 | Read data, combinational |
| irr_in | input | 8 | Request register from the priority core |
| isr_in | input | 8 | In-service register from the priority core |
| isr_top_valid | input | 1 | At least one level in service |
| isr_top_lvl | input | 3 | Absolute level of highest-priority in-service bit |
| mask | output | 8 | Interrupt mask |
| vec_base | output | 5 | Vector base, upper five bits |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| rot_off | output | 3 | Priority rotation offset |
| rd_sel_isr | output | 1 | Reads at address 0 return in-service register |
| spec_mask | output | 1 | Special mask mode |
| rot_auto_eoi | output | 1 | Rotate on automatic end-of-interrupt |
| fourth_expected | output | 1 | Initialization expects a fourth word |
| init_busy | output | 1 | Initialization sequence in progress |
| mode_unsup | output | 1 | Last initialization word requested an unsupported mode |
| core_clear | output | 1 | One-cycle pulse: flush core state |
| isr_clr | output | 8 | One-cycle pulse mask of in-service bits to clear |

## Verification
The hardest case to reach is a full initialization sequence that includes the optional fourth word. Every address-1 write along that path must be interpreted by sequence state and not as a mask load. Random stimulus tends to break such a sequence with a fresh initialization word, or to end it early. Directed sequences therefore cover both the fourth-word and no-fourth-word paths. The random mix also weights initialization words low, so that long runs of address-1 writes occur within sequences. Non-specific end-of-interrupt with nothing in service, and wrap of the rotation offset from 7 to 0, are also driven directly.

// File: rtl/picport_pkg.sv
package picport_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_BASE, SEQ_SKIP, SEQ_MODE} seq_t;
  typedef enum logic [2:0] {K_NONE, K_INIT, K_CTRL, K_PRIO, K_DATA} kind_t;
  typedef enum logic [2:0] {
    P_NOP, P_RAE_CLR, P_RAE_SET, P_NSEOI, P_NSEOI_ROT, P_SEOI, P_SETPRI, P_SEOI_ROT
  } prio_t;
endpackage

// File: rtl/picport_decode.sv
module picport_decode
  import picport_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  output kind_t         kind,
  output prio_t         pop,
  output logic [LW-1:0] lvl
);
  logic low_zero;
  assign low_zero = (wr_data[LW-1:0] == '0);
  assign lvl      = wr_data[LW-1:0];

  always_comb begin
    kind = K_NONE;
    pop  = P_NOP;
    if (wr_en) begin
      if (wr_addr)         kind = K_DATA;
      else if (wr_data[4]) kind = K_INIT;
      else if (wr_data[3]) kind = K_CTRL;
      else begin
        kind = K_PRIO;
        case (wr_data[7:5])
          3'b000:  pop = low_zero ? P_RAE_CLR : P_NOP;
          3'b100:  pop = low_zero ? P_RAE_SET : P_NOP;
          3'b001:  pop = low_zero ? P_NSEOI : P_NOP;
          3'b101:  pop = low_zero ? P_NSEOI_ROT : P_NOP;
          3'b011:  pop = P_SEOI;
          3'b110:  pop = P_SETPRI;
          3'b111:  pop = P_SEOI_ROT;
          default: pop = P_NOP;
        endcase
      end
    end
  end
endmodule

// File: rtl/picport_initseq.sv
module picport_initseq
  import picport_pkg::*;
#(
  parameter int DW = 8,
  parameter int VW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  kind_t         kind,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] mask,
  output logic [VW-1:0] vec_base,
  output logic          auto_eoi,
  output logic          fourth_expected,
  output logic          init_busy,
  output logic          mode_unsup,
  output logic          core_clear
);
  seq_t state;
  assign init_busy = (state != SEQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state           <= SEQ_IDLE;
      mask            <= '0;
      vec_base        <= '0;
      auto_eoi        <= 1'b0;
      fourth_expected <= 1'b0;
      mode_unsup      <= 1'b0;
      core_clear      <= 1'b0;
    end else begin
      core_clear <= 1'b0;
      if (kind == K_INIT) begin
        mask            <= '0;
        vec_base        <= '0;
        auto_eoi        <= 1'b0;
        fourth_expected <= wr_data[0];
        mode_unsup      <= wr_data[1] | wr_data[3];
        core_clear      <= 1'b1;
        state           <= SEQ_BASE;
      end else if (kind == K_DATA) begin
        case (state)
          SEQ_IDLE: mask <= wr_data;
          SEQ_BASE: begin
            vec_base <= wr_data[DW-1:DW-VW];
            state    <= SEQ_SKIP;
          end
          SEQ_SKIP: state <= fourth_expected ? SEQ_MODE : SEQ_IDLE;
          default: begin
            auto_eoi <= wr_data[1];
            state    <= SEQ_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/picport_opunit.sv
module picport_opunit
  import picport_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LINES = 8,
  parameter int LW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  kind_t            kind,
  input  prio_t            pop,
  input  logic [LW-1:0]    lvl,
  input  logic [DW-1:0]    wr_data,
  input  logic             isr_top_valid,
  input  logic [LW-1:0]    isr_top_lvl,
  output logic [LW-1:0]    rot_off,
  output logic             rd_sel_isr,
  output logic             spec_mask,
  output logic             rot_auto_eoi,
  output logic [LINES-1:0] isr_clr
);
  localparam logic [LINES-1:0] ONE = LINES'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_off      <= '0;
      rd_sel_isr   <= 1'b0;
      spec_mask    <= 1'b0;
      rot_auto_eoi <= 1'b0;
      isr_clr      <= '0;
    end else begin
      isr_clr <= '0;
      case (kind)
        K_INIT: begin
          rot_off      <= '0;
          rd_sel_isr   <= 1'b0;
          spec_mask    <= 1'b0;
          rot_auto_eoi <= 1'b0;
        end
        K_CTRL: begin
          if (wr_data[1]) rd_sel_isr <= wr_data[0];
          if (wr_data[6]) spec_mask  <= wr_data[5];
        end
        K_PRIO: begin
          case (pop)
            P_RAE_CLR: rot_auto_eoi <= 1'b0;
            P_RAE_SET: rot_auto_eoi <= 1'b1;
            P_NSEOI, P_NSEOI_ROT: begin
              if (isr_top_valid) isr_clr <= ONE << isr_top_lvl;
              if (pop == P_NSEOI_ROT) rot_off <= rot_off + 1'b1;
            end
            P_SEOI:   isr_clr <= ONE << lvl;
            P_SETPRI: rot_off <= lvl + 1'b1;
            P_SEOI_ROT: begin
              isr_clr <= ONE << lvl;
              rot_off <= lvl + 1'b1;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/picport_top.sv
module picport_top
  import picport_pkg::*;
#(
  parameter int LINES = 8,
  parameter int DW    = 8,
  parameter int VW    = 5,
  parameter int LW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic [LINES-1:0] irr_in,
  input  logic [LINES-1:0] isr_in,
  input  logic             isr_top_valid,
  input  logic [LW-1:0]    isr_top_lvl,
  output logic [DW-1:0]    mask,
  output logic [VW-1:0]    vec_base,
  output logic             auto_eoi,
  output logic [LW-1:0]    rot_off,
  output logic             rd_sel_isr,
  output logic             spec_mask,
  output logic             rot_auto_eoi,
  output logic             fourth_expected,
  output logic             init_busy,
  output logic             mode_unsup,
  output logic             core_clear,
  output logic [LINES-1:0] isr_clr
);
  kind_t         kind;
  prio_t         pop;
  logic [LW-1:0] lvl;

  picport_decode #(.DW(DW), .LW(LW)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .kind(kind), .pop(pop), .lvl(lvl)
  );

  picport_initseq #(.DW(DW), .VW(VW)) u_seq (
    .clk(clk), .rst_n(rst_n), .kind(kind), .wr_data(wr_data),
    .mask(mask), .vec_base(vec_base), .auto_eoi(auto_eoi),
    .fourth_expected(fourth_expected), .init_busy(init_busy),
    .mode_unsup(mode_unsup), .core_clear(core_clear)
  );

  picport_opunit #(.DW(DW), .LINES(LINES), .LW(LW)) u_op (
    .clk(clk), .rst_n(rst_n), .kind(kind), .pop(pop), .lvl(lvl),
    .wr_data(wr_data), .isr_top_valid(isr_top_valid), .isr_top_lvl(isr_top_lvl),
    .rot_off(rot_off), .rd_sel_isr(rd_sel_isr), .spec_mask(spec_mask),
    .rot_auto_eoi(rot_auto_eoi), .isr_clr(isr_clr)
  );

  always_comb begin
    if (rd_addr)         rd_data = mask;
    else if (rd_sel_isr) rd_data = DW'(isr_in);
    else                 rd_data = DW'(irr_in);
  end
endmodule

// File: rtl/picport_chk.sv
module picport_chk #(
  parameter int LINES = 8,
  parameter int DW    = 8,
  parameter int LW    = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic             rd_addr,
  input logic [DW-1:0]    rd_data,
  input logic             isr_top_valid,
  input logic [LW-1:0]    isr_top_lvl,
  input logic [DW-1:0]    mask,
  input logic [LW-1:0]    rot_off,
  input logic             spec_mask,
  input logic             init_busy,
  input logic             core_clear,
  input logic [LINES-1:0] isr_clr
);
  logic wr0;
  assign wr0 = wr_en && !wr_addr;

  assert_init_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && wr_data[4]) |=> (mask == '0 && rot_off == '0 && init_busy && core_clear));

  assert_nseoi_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && wr_data == 8'h20 && isr_top_valid) |=>
      (isr_clr == (LINES'(1) << $past(isr_top_lvl))));

  assert_clr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_clr));

  assert_setpri_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && wr_data[7:3] == 5'b11000) |=> (rot_off == LW'($past(wr_data[2:0]) + 3'd1)));

  assert_rd_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr |-> (rd_data == mask));

  assert_quiet_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mask) && $stable(rot_off) && $stable(spec_mask)
                && isr_clr == '0 && !core_clear));
endmodule

bind picport_top picport_chk #(.LINES(LINES), .DW(DW), .LW(LW)) u_chk (.*);

// File: tb/picport_top_test.sv
`timescale 1ns/1ps
module picport_top_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0, wr_addr = 0, rd_addr = 0, isr_top_valid = 0;
  logic [7:0] wr_data = 0, irr_in = 0, isr_in = 0, rd_data, mask, isr_clr;
  logic [2:0] isr_top_lvl = 0, rot_off;
  logic [4:0] vec_base;
  logic auto_eoi, rd_sel_isr, spec_mask, rot_auto_eoi, fourth_expected;
  logic init_busy, mode_unsup, core_clear;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_mask, m_clr;
  logic [4:0] m_vec;
  logic [2:0] m_rot;
  logic m_aeoi, m_w4, m_unsup, m_cc, m_rdisr, m_smask, m_rae;
  int   m_st;

  always #10 clk = ~clk;

  picport_top uut (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mask = 0; m_vec = 0; m_rot = 0; m_aeoi = 0; m_w4 = 0; m_unsup = 0;
    m_cc = 0; m_rdisr = 0; m_smask = 0; m_rae = 0; m_st = 0; m_clr = 0;
  endtask

  task automatic model_write(logic a, logic [7:0] d, logic tv, logic [2:0] tl);
    m_clr = 0; m_cc = 0;
    if (a) begin
      case (m_st)
        0: m_mask = d;                                  // R3
        1: begin m_vec = d[7:3]; m_st = 2; end          // R2
        2: m_st = m_w4 ? 3 : 0;
        default: begin m_aeoi = d[1]; m_st = 0; end
      endcase
    end else if (d[4]) begin                            // R1
      m_mask = 0; m_vec = 0; m_aeoi = 0; m_rot = 0; m_rdisr = 0;
      m_smask = 0; m_rae = 0; m_w4 = d[0]; m_unsup = d[1] | d[3];
      m_cc = 1; m_st = 1;
    end else if (d[3]) begin                            // R4
      if (d[1]) m_rdisr = d[0];
      if (d[6]) m_smask = d[5];
    end else begin
      if (d == 8'h00) m_rae = 0;                        // R5
      else if (d == 8'h80) m_rae = 1;
      else if (d == 8'h20 || d == 8'hA0) begin          // R6, R7
        if (tv) m_clr = 8'(1) << tl;
        if (d == 8'hA0) m_rot = m_rot + 3'd1;
      end else if (d[7:5] == 3'b011) m_clr = 8'(1) << d[2:0];   // R8
      else if (d[7:5] == 3'b110) m_rot = d[2:0] + 3'd1;         // R9
      else if (d[7:5] == 3'b111) begin                          // R10
        m_clr = 8'(1) << d[2:0];
        m_rot = d[2:0] + 3'd1;
      end
      // any other code: R11, no change
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "mask", mask, m_mask);
    chk(req, "vec_base", vec_base, m_vec);
    chk(req, "auto_eoi", auto_eoi, m_aeoi);
    chk(req, "rot_off", rot_off, m_rot);
    chk(req, "rd_sel_isr", rd_sel_isr, m_rdisr);
    chk(req, "spec_mask", spec_mask, m_smask);
    chk(req, "rot_auto_eoi", rot_auto_eoi, m_rae);
    chk(req, "fourth_expected", fourth_expected, m_w4);
    chk(req, "init_busy", init_busy, m_st != 0);
    chk(req, "mode_unsup", mode_unsup, m_unsup);
    chk(req, "core_clear", core_clear, m_cc);
    chk(req, "isr_clr", isr_clr, m_clr);
  endtask

  task automatic wr(string req, logic a, logic [7:0] d, logic tv = 0, logic [2:0] tl = 0);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; isr_top_valid = tv; isr_top_lvl = tl;
    model_write(a, d, tv, tl);
    @(negedge clk);
    wr_en = 0; isr_top_valid = ~tv;
    chk_all(req);
  endtask

  task automatic idle_chk();
    @(negedge clk);
    m_clr = 0; m_cc = 0;
    chk_all("R13");
  endtask

  task automatic rd_chk(string req);
    rd_addr = 1'($urandom); irr_in = 8'($urandom); isr_in = 8'($urandom);
    #1;
    chk(req, "rd_data", rd_data, rd_addr ? m_mask : (m_rdisr ? isr_in : irr_in));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    chk_all("R13");
    rst_n = 1;
    idle_chk();

    // full sequence with fourth word (R2)
    wr("R1", 0, 8'h13);
    wr("R2", 1, 8'h47);
    wr("R2", 1, 8'hFF);
    wr("R2", 1, 8'h02);
    wr("R3", 1, 8'hA5);
    rd_chk("R12");
    // sequence without fourth word
    wr("R1", 0, 8'h18);
    wr("R2", 1, 8'hF8);
    wr("R2", 1, 8'h02);
    wr("R3", 1, 8'h3C);
    // control words
    wr("R4", 0, 8'h0B);
    rd_chk("R12");
    wr("R4", 0, 8'h68);
    wr("R4", 0, 8'h08);
    wr("R5", 0, 8'h80);
    wr("R5", 0, 8'h00);
    // end-of-interrupt forms
    wr("R6", 0, 8'h20, 1, 3'd5);
    idle_chk();
    wr("R6", 0, 8'h20, 0, 3'd5);
    wr("R9", 0, 8'hC6);
    wr("R7", 0, 8'hA0, 0, 3'd2);
    wr("R7", 0, 8'hA0, 1, 3'd7);
    wr("R8", 0, 8'h63);
    wr("R10", 0, 8'hE7);
    wr("R11", 0, 8'h21, 1, 3'd1);
    wr("R11", 0, 8'h45);
    wr("R11", 0, 8'hA3, 1, 3'd0);
    wr("R11", 0, 8'h01);

    for (int i = 0; i < 600; i++) begin
      int cls;
      logic [7:0] d;
      cls = int'($urandom % 16);
      if (cls == 0)      wr("R1", 0, 8'($urandom) | 8'h10);
      else if (cls < 6)  wr("R2", 1, 8'($urandom));
      else if (cls < 8)  wr("R4", 0, (8'($urandom) & 8'hE7) | 8'h08);
      else begin
        d = {3'($urandom), 5'b0};
        if ($urandom % 4 == 0) d[2:0] = 3'($urandom);
        wr("R13", 0, d, 1'($urandom), 3'($urandom));
      end
      if ($urandom % 4 == 0) idle_chk();
      rd_chk("R12");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule